// File: doc/BRIEF.md
# Line Permission Checker

This block sits beside a processor's load/store path and decides whether each memory access may go ahead. For every tracked cache line of the node it keeps two bits: one allowing the node to read the line and one allowing it to write it. These bits are not tied to the coherence state of the on-chip caches, so any hardware protocol can run underneath. An access that lacks the bit it needs does not complete. Instead the block raises a coherence trap that a software handler services. All lookups use the physical address, so every virtual alias of a line sees the same permission.

Each access is presented for one cycle with its address, a load/store flag and a requester ID. One cycle later the block reports exactly one outcome: a grant, or a trap carrying the line-aligned address, the access kind and the ID. A trap stays up until the handler acknowledges it. While it is up, the core is expected to stall, and accesses presented during that time are ignored. A software update port lets the handler write both bits of any line. An update takes precedence over a lookup of the same line in the same cycle.

Top module: `perm_checker`

## Requirements
- R1: After reset, lines with index HOME_FIRST..HOME_LAST (default 8..15) hold both read and write permission, every other line holds neither, and grant_valid and trap_valid are low.
- R2: A load (acc_store=0) accepted in cycle t to a line whose read bit is set gives grant_valid high for exactly cycle t+1, with grant_id equal to the request's acc_id.
- R3: A store (acc_store=1) needs the write bit; a store to a line holding read but not write permission traps, and a store to a line with the write bit set is granted.
- R4: An accepted access lacking its bit raises trap_valid in cycle t+1 with no grant, trap_addr equal to acc_addr with its low log2(LINE_BYTES) bits cleared, trap_store equal to acc_store (1 = store, 0 = load) and trap_id equal to acc_id.
- R5: trap_valid and its trap_addr, trap_store and trap_id fields hold unchanged until trap_ack is sampled high, and trap_valid is low in the cycle after that.
- R6: An access presented while trap_valid is high (including the cycle of trap_ack) is ignored: it causes no grant and no new trap, and it leaves the trap fields unchanged.
- R7: When sw_we is high, sw_read_ok and sw_write_ok become the read and write bits of line sw_line, and they govern every lookup from the next cycle on.
- R8: A lookup in the same cycle as a software write to its own line is decided by the newly written bits.
- R9: The line index is (acc_addr / LINE_BYTES) mod LINES. Addresses that differ only in the offset bits, or only in bits above the index, share one permission entry.
- R10: Every accepted access gets exactly one outcome. A grant is given whenever the needed bit is set, and no trap is raised without a missing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW | Physical byte address of the access |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_id | input | IW | Requester/thread ID |
| grant_valid | output | 1 | Access in the previous cycle may proceed |
| grant_id | output | IW | ID of the granted access |
| trap_valid | output | 1 | Coherence trap pending |
| trap_addr | output | AW | Line-aligned address of the faulting access |
| trap_store | output | 1 | Faulting access was a store |
| trap_id | output | IW | ID of the faulting access |
| trap_ack | input | 1 | Handler acknowledges the pending trap |
| sw_we | input | 1 | Software permission write strobe |
| sw_line | input | log2(LINES) | Line index to update |
| sw_read_ok | input | 1 | New read bit |
| sw_write_ok | input | 1 | New write bit |

## Verification
The hardest case is an access that meets a software write to its own line in the same cycle. When that write flips the line's permission, the grant or trap outcome depends on the new value, which is not yet in storage. The stimulus sets up a line with one permission, then writes the opposite value in the very cycle a load or store to that line is presented, in both directions. A random phase adds further collisions, wrapped addresses and acknowledges that land in the same cycle as new accesses. A behavioural model checks all of it cycle by cycle.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;

    typedef struct packed {
        logic rd;
        logic wr;
    } perm_t;

    localparam perm_t PERM_NONE = '{rd: 1'b0, wr: 1'b0};
    localparam perm_t PERM_FULL = '{rd: 1'b1, wr: 1'b1};

endpackage

// File: rtl/perm_store.sv
module perm_store
    import perm_chk_pkg::*;
#(
    parameter  int LINES      = 64,
    parameter  int HOME_FIRST = 8,
    parameter  int HOME_LAST  = 15,
    localparam int IDX_W      = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_line,
    input  perm_t            upd_perm,
    input  logic [IDX_W-1:0] look_line,
    output perm_t            look_perm
);

    perm_t tbl_d [LINES];
    perm_t tbl_q [LINES];

    function automatic perm_t home_value(input int idx);
        return (idx >= HOME_FIRST && idx <= HOME_LAST) ? PERM_FULL : PERM_NONE;
    endfunction

    always_comb begin
        tbl_d = tbl_q;
        if (upd_en) begin
            tbl_d[upd_line] = upd_perm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tbl_q[i] <= home_value(i);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign look_perm = tbl_q[look_line];

endmodule

// File: rtl/perm_lookup.sv
module perm_lookup
    import perm_chk_pkg::*;
#(
    parameter  int AW         = 32,
    parameter  int LINES      = 64,
    parameter  int LINE_BYTES = 64,
    localparam int IDX_W      = $clog2(LINES),
    localparam int OFS_W      = $clog2(LINE_BYTES)
) (
    input  logic [AW-1:0]    acc_addr,
    input  logic             acc_store,
    input  perm_t            stored_perm,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_line,
    input  perm_t            upd_perm,
    output logic [IDX_W-1:0] line_idx,
    output logic [AW-1:0]    line_addr,
    output logic             allow
);

    localparam logic [AW-1:0] OFS_MASK = AW'(LINE_BYTES - 1);

    perm_t eff_perm;

    always_comb begin
        line_idx  = acc_addr[OFS_W +: IDX_W];
        line_addr = acc_addr & ~OFS_MASK;
        if (upd_en && (upd_line == line_idx)) begin
            eff_perm = upd_perm;
        end else begin
            eff_perm = stored_perm;
        end
        allow = acc_store ? eff_perm.wr : eff_perm.rd;
    end

endmodule

// File: rtl/perm_resp.sv
module perm_resp #(
    parameter int AW = 32,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_store,
    input  logic [IW-1:0] acc_id,
    input  logic [AW-1:0] line_addr,
    input  logic          allow,
    input  logic          trap_ack,
    output logic          grant_valid,
    output logic [IW-1:0] grant_id,
    output logic          trap_valid,
    output logic [AW-1:0] trap_addr,
    output logic          trap_store,
    output logic [IW-1:0] trap_id
);

    typedef struct packed {
        logic          grant;
        logic [IW-1:0] gid;
        logic          trap;
        logic [AW-1:0] taddr;
        logic          tstore;
        logic [IW-1:0] tid;
    } resp_t;

    resp_t st_d;
    resp_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        if (st_q.trap) begin
            if (trap_ack) begin
                st_d.trap = 1'b0;
            end
        end else if (acc_valid) begin
            if (allow) begin
                st_d.grant = 1'b1;
                st_d.gid   = acc_id;
            end else begin
                st_d.trap   = 1'b1;
                st_d.taddr  = line_addr;
                st_d.tstore = acc_store;
                st_d.tid    = acc_id;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.grant;
    assign grant_id    = st_q.gid;
    assign trap_valid  = st_q.trap;
    assign trap_addr   = st_q.taddr;
    assign trap_store  = st_q.tstore;
    assign trap_id     = st_q.tid;

endmodule

// File: rtl/perm_checker.sv
module perm_checker
    import perm_chk_pkg::*;
#(
    parameter  int AW         = 32,
    parameter  int IW         = 4,
    parameter  int LINES      = 64,
    parameter  int LINE_BYTES = 64,
    parameter  int HOME_FIRST = 8,
    parameter  int HOME_LAST  = 15,
    localparam int IDX_W      = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [AW-1:0]    acc_addr,
    input  logic             acc_store,
    input  logic [IW-1:0]    acc_id,
    output logic             grant_valid,
    output logic [IW-1:0]    grant_id,
    output logic             trap_valid,
    output logic [AW-1:0]    trap_addr,
    output logic             trap_store,
    output logic [IW-1:0]    trap_id,
    input  logic             trap_ack,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_line,
    input  logic             sw_read_ok,
    input  logic             sw_write_ok
);

    perm_t            upd_perm;
    perm_t            stored_perm;
    logic [IDX_W-1:0] line_idx;
    logic [AW-1:0]    line_addr;
    logic             allow;

    assign upd_perm = '{rd: sw_read_ok, wr: sw_write_ok};

    perm_store #(
        .LINES      (LINES),
        .HOME_FIRST (HOME_FIRST),
        .HOME_LAST  (HOME_LAST)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (sw_we),
        .upd_line  (sw_line),
        .upd_perm  (upd_perm),
        .look_line (line_idx),
        .look_perm (stored_perm)
    );

    perm_lookup #(
        .AW         (AW),
        .LINES      (LINES),
        .LINE_BYTES (LINE_BYTES)
    ) u_lookup (
        .acc_addr    (acc_addr),
        .acc_store   (acc_store),
        .stored_perm (stored_perm),
        .upd_en      (sw_we),
        .upd_line    (sw_line),
        .upd_perm    (upd_perm),
        .line_idx    (line_idx),
        .line_addr   (line_addr),
        .allow       (allow)
    );

    perm_resp #(
        .AW (AW),
        .IW (IW)
    ) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_store   (acc_store),
        .acc_id      (acc_id),
        .line_addr   (line_addr),
        .allow       (allow),
        .trap_ack    (trap_ack),
        .grant_valid (grant_valid),
        .grant_id    (grant_id),
        .trap_valid  (trap_valid),
        .trap_addr   (trap_addr),
        .trap_store  (trap_store),
        .trap_id     (trap_id)
    );

endmodule

// File: rtl/perm_checker_sva.sv
module perm_checker_sva #(
    parameter int AW    = 32,
    parameter int IW    = 4,
    parameter int OFS_W = 6,
    parameter int LW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [AW-1:OFS_W] acc_line,
    input logic             acc_store,
    input logic [IW-1:0]    acc_id,
    input logic             grant_valid,
    input logic [IW-1:0]    grant_id,
    input logic             trap_valid,
    input logic [AW-1:0]    trap_addr,
    input logic             trap_store,
    input logic [IW-1:0]    trap_id,
    input logic             trap_ack,
    input logic             sw_we,
    input logic [LW-1:0]    sw_line,
    input logic             sw_read_ok,
    input logic             sw_write_ok
);

    logic taken;
    logic same_line;
    logic new_ok;

    assign taken     = acc_valid && !trap_valid;
    assign same_line = sw_we && (sw_line == acc_line[OFS_W +: LW]);
    assign new_ok    = acc_store ? sw_write_ok : sw_read_ok;

    a_r5_trap_held: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !trap_ack |=> trap_valid && $stable(trap_addr)
            && $stable(trap_store) && $stable(trap_id));

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && trap_ack |=> !trap_valid);

    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> grant_valid != trap_valid);

    a_r6_no_spurious_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> !grant_valid);

    a_r4_trap_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> trap_addr[OFS_W-1:0] == '0);

    a_r4_trap_fields: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !trap_valid || (trap_id == $past(acc_id)
            && trap_store == $past(acc_store)
            && trap_addr[AW-1:OFS_W] == $past(acc_line)));

    a_r2_grant_id: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !grant_valid || grant_id == $past(acc_id));

    a_r8_bypass_grant: assert property (@(posedge clk) disable iff (!rst_n)
        taken && same_line && new_ok |=> grant_valid);

    a_r8_bypass_trap: assert property (@(posedge clk) disable iff (!rst_n)
        taken && same_line && !new_ok |=> trap_valid);

endmodule

bind perm_checker perm_checker_sva #(
    .AW    (AW),
    .IW    (IW),
    .OFS_W ($clog2(LINE_BYTES)),
    .LW    (IDX_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_line    (acc_addr[AW-1:$clog2(LINE_BYTES)]),
    .acc_store   (acc_store),
    .acc_id      (acc_id),
    .grant_valid (grant_valid),
    .grant_id    (grant_id),
    .trap_valid  (trap_valid),
    .trap_addr   (trap_addr),
    .trap_store  (trap_store),
    .trap_id     (trap_id),
    .trap_ack    (trap_ack),
    .sw_we       (sw_we),
    .sw_line     (sw_line),
    .sw_read_ok  (sw_read_ok),
    .sw_write_ok (sw_write_ok)
);

// File: tb/perm_checker_bench.sv
`timescale 1ns/1ps
module perm_checker_bench;

    localparam int AW = 32;
    localparam int IW = 4;
    localparam int LINES = 64;
    localparam int LINE_BYTES = 64;
    localparam int HOME_FIRST = 8;
    localparam int HOME_LAST = 15;
    localparam int LW = $clog2(LINES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic acc_store = 1'b0;
    logic [IW-1:0] acc_id = '0;
    logic grant_valid;
    logic [IW-1:0] grant_id;
    logic trap_valid;
    logic [AW-1:0] trap_addr;
    logic trap_store;
    logic [IW-1:0] trap_id;
    logic trap_ack = 1'b0;
    logic sw_we = 1'b0;
    logic [LW-1:0] sw_line = '0;
    logic sw_read_ok = 1'b0;
    logic sw_write_ok = 1'b0;

    always #10 clk = ~clk;

    perm_checker #(
        .AW(AW), .IW(IW), .LINES(LINES), .LINE_BYTES(LINE_BYTES),
        .HOME_FIRST(HOME_FIRST), .HOME_LAST(HOME_LAST)
    ) u_perm_checker (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_store(acc_store), .acc_id(acc_id),
        .grant_valid(grant_valid), .grant_id(grant_id),
        .trap_valid(trap_valid), .trap_addr(trap_addr), .trap_store(trap_store), .trap_id(trap_id),
        .trap_ack(trap_ack),
        .sw_we(sw_we), .sw_line(sw_line), .sw_read_ok(sw_read_ok), .sw_write_ok(sw_write_ok)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    bit m_rd [LINES];
    bit m_wr [LINES];
    bit m_trap = 0;
    logic [AW-1:0] m_taddr = '0;
    bit m_tstore = 0;
    logic [IW-1:0] m_tid = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int line, input int off, input int hi);
        return AW'(hi) * AW'(LINE_BYTES * LINES) + AW'(line * LINE_BYTES + off);
    endfunction

    // One cycle: drive at the falling edge, predict, compare at the next falling edge.
    task automatic cyc(input string tag, input bit v, input logic [AW-1:0] a, input bit st,
                       input int id, input bit ack, input bit we, input int wl,
                       input bit wr_r, input bit wr_w);
        int idx;
        bit eff_rd, eff_wr, ok, e_grant;
        acc_valid = v; acc_addr = a; acc_store = st; acc_id = IW'(id);
        trap_ack = ack; sw_we = we; sw_line = LW'(wl);
        sw_read_ok = wr_r; sw_write_ok = wr_w;
        idx = int'((a / LINE_BYTES) % LINES);
        eff_rd = (we && wl == idx) ? wr_r : m_rd[idx];
        eff_wr = (we && wl == idx) ? wr_w : m_wr[idx];
        ok = st ? eff_wr : eff_rd;
        e_grant = 0;
        if (m_trap) begin
            if (ack) m_trap = 0;
        end else if (v) begin
            if (ok) e_grant = 1;
            else begin
                m_trap = 1;
                m_taddr = a & ~AW'(LINE_BYTES - 1);
                m_tstore = st;
                m_tid = IW'(id);
            end
        end
        if (we) begin
            m_rd[wl] = wr_r;
            m_wr[wl] = wr_w;
        end
        @(posedge clk);
        @(negedge clk);
        chk(grant_valid == e_grant, tag, "grant_valid", grant_valid, e_grant);
        if (e_grant) chk(grant_id == IW'(id), tag, "grant_id", grant_id, id);
        chk(trap_valid == m_trap, tag, "trap_valid", trap_valid, m_trap);
        if (m_trap) begin
            chk(trap_addr == m_taddr, tag, "trap_addr", trap_addr, m_taddr);
            chk(trap_store == m_tstore, tag, "trap_store", trap_store, m_tstore);
            chk(trap_id == m_tid, tag, "trap_id", trap_id, m_tid);
        end
    endtask

    task automatic acc(input string tag, input int line, input int off, input int hi,
                       input bit st, input int id);
        cyc(tag, 1, mk(line, off, hi), st, id, 0, 0, 0, 0, 0);
    endtask

    task automatic sw(input string tag, input int line, input bit r, input bit w);
        cyc(tag, 0, '0, 0, 0, 0, 1, line, r, w);
    endtask

    task automatic ack_it(input string tag);
        cyc(tag, 0, '0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_rd[i] = (i >= HOME_FIRST && i <= HOME_LAST);
            m_wr[i] = (i >= HOME_FIRST && i <= HOME_LAST);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the outputs
        chk(grant_valid == 0, "R1", "grant_valid after reset", grant_valid, 0);
        chk(trap_valid == 0, "R1", "trap_valid after reset", trap_valid, 0);
        // R1: home lines full, others empty
        acc("R1", HOME_FIRST, 4, 0, 0, 1);
        acc("R1", HOME_LAST, 0, 0, 1, 2);
        acc("R1", 3, 8, 0, 0, 3);
        ack_it("R1");
        acc("R1", HOME_LAST + 1, 0, 0, 1, 4);
        ack_it("R1");
        // R2: read-only line grants loads
        sw("R7", 20, 1, 0);
        acc("R2", 20, 12, 0, 0, 5);
        // R3: store to read-only line traps with store flag
        acc("R3", 20, 0, 0, 1, 6);
        ack_it("R3");
        acc("R3", 10, 63, 0, 1, 7);
        // R4: load to empty line traps with aligned address
        acc("R4", 40, 37, 2, 0, 9);
        // R5: trap held without acknowledge
        cyc("R5", 0, '0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R5", 0, '0, 0, 0, 0, 0, 0, 0, 0);
        // R6: accesses while trap pending are ignored, also in the ack cycle
        acc("R6", 10, 0, 0, 0, 11);
        acc("R6", 41, 0, 0, 1, 12);
        cyc("R6", 1, mk(10, 0, 0), 0, 13, 1, 0, 0, 0, 0);
        acc("R6", 10, 0, 0, 0, 14);
        // R7: software clears a home line, later load traps
        sw("R7", 9, 0, 0);
        acc("R7", 9, 0, 0, 0, 1);
        ack_it("R7");
        sw("R7", 9, 1, 1);
        acc("R7", 9, 0, 0, 1, 2);
        // R8: same-cycle write to the accessed line decides the outcome
        cyc("R8", 1, mk(30, 5, 0), 1, 3, 0, 1, 30, 0, 1);
        cyc("R8", 1, mk(10, 5, 0), 0, 4, 0, 1, 10, 0, 0);
        ack_it("R8");
        cyc("R8", 1, mk(31, 0, 0), 0, 5, 0, 1, 32, 1, 1);
        ack_it("R8");
        // R9: offset and upper-bit aliases share the entry
        acc("R9", 20, 63, 5, 0, 6);
        acc("R9", 20, 1, 7, 1, 7);
        ack_it("R9");
        // R10: random mix
        for (int k = 0; k < 600; k++) begin
            int ln;
            ln = int'($urandom_range(0, LINES - 1));
            cyc("R10", bit'($urandom_range(0, 1)),
                mk(ln, int'($urandom_range(0, LINE_BYTES - 1)), int'($urandom_range(0, 15))),
                bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                ($urandom_range(0, 2) == 0), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 1) == 0) ? ln : int'($urandom_range(0, LINES - 1)),
                bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
        end
        finish_run();
    end

endmodule